// File: doc/BRIEF.md
# Four-Group Carry Lookahead Generator and Lookahead Adder

The lookahead unit is purely combinational. It takes generate and propagate signals from four adder groups, each pair active low, and one active-high carry input. From these it produces three active-high carries, one into each of groups 1, 2 and 3. It also produces a block generate and a block propagate, both active low. Because the block outputs have the same polarity as the group inputs, one unit's block outputs can feed straight into the group inputs of a unit one level up. The unit does not form the carry out of group 3. The unit that receives its block signals forms that carry.

The top module builds a WIDTH-bit adder from 4-bit slices. Each slice reports an active-low group generate and propagate for its four bits. The slices are grouped in fours under first-level lookahead units. Carries between first-level units are produced in one of two ways. In the default mode they ripple from one unit to the next. When TWO_LEVEL is set and there are two to four units, a second-level unit computes them instead. If the last unit has fewer than four slices, its unused group inputs are tied to "no generate, propagate", so the carries pass straight through them. This makes widths such as 28 bits work. The wiring between the slices and the units is the same for any operand encoding, because the units only combine group generate and propagate signals.

Top module: `lookahead_adder`

## Requirements
- R1: The first carry output of the unit (into group 1) is high exactly when group 0 generates, or when group 0 propagates and the carry input is high. A group input pair is asserted when its bit is 0.
- R2: The second carry output is high exactly when G1, or P1·G0, or P1·P0·Cin holds, where G and P are the inverted (true-sense) group inputs.
- R3: The third carry output is high exactly when G2, or P2·G1, or P2·P1·G0, or P2·P1·P0·Cin holds.
- R4: The block generate output is 0 exactly when G3, or P3·G2, or P3·P2·G1, or P3·P2·P1·G0 holds. Its value does not depend on the carry input.
- R5: The block propagate output is 0 only when all four group propagate inputs are 0. Any propagate input at 1 drives it to 1.
- R6: For all 512 combinations of the unit's nine inputs, every output is a defined 0 or 1.
- R7: With the default ripple mode, {cout, sum} of the top equals a + b + cin for every operand pair at a WIDTH that is a multiple of 16.
- R8: When the slice count is not a multiple of four (for example WIDTH = 28), the padded group positions pass the carry through. The carry ripples correctly across units, including a full-length propagate chain (all ones plus carry in).
- R9: With TWO_LEVEL set, a second-level unit fed by the first-level block outputs, with no inversion between them, gives the same exact sum and carry out as the ripple mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0, active high |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit, active high |

## Verification
The design holds no state, so any fault in the lookahead equations appears at the outputs for the same input vector that exercises it. A wrong product term in a carry equation corrupts a sum bit at the boundary of the next group. It does so only for the inputs where that term decides the carry, which is why the unit gets a full sweep of its nine inputs and the small adder a full sweep of its operands. A fault in the padding of partial groups, or in the carries between units, shows up only at widths that leave groups empty. It is also revealed by long propagate chains, such as all ones plus carry in, so these cases are driven directly.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP = 4;
  typedef logic [GRP-1:0] grp_t;
endpackage

// File: rtl/add4_slice.sv
module add4_slice
  import cla_pkg::*;
(
  input  grp_t a,
  input  grp_t b,
  input  logic ci,
  output grp_t s,
  output logic g_n,
  output logic p_n
);
  logic c;
  logic gg;
  always_comb begin
    c  = ci;
    gg = 1'b0;
    s  = '0;
    for (int i = 0; i < GRP; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
      gg   = (a[i] & b[i]) | ((a[i] ^ b[i]) & gg);
    end
    g_n = ~gg;
    p_n = ~(&(a ^ b));
  end
endmodule

// File: rtl/cla4_gen.sv
module cla4_gen
  import cla_pkg::*;
(
  input  grp_t g_n,
  input  grp_t p_n,
  input  logic cin,
  output logic c1,
  output logic c2,
  output logic c3,
  output logic bg_n,
  output logic bp_n
);
  grp_t g, p;
  always_comb begin
    g    = ~g_n;
    p    = ~p_n;
    c1   = g[0] | (p[0] & cin);
    c2   = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    c3   = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & cin);
    bg_n = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]));
    bp_n = ~(&p);
  end
endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter bit          TWO_LEVEL = 1'b0
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int unsigned NSLICE = WIDTH / GRP;
  localparam int unsigned NUNIT  = (NSLICE + GRP - 1) / GRP;
  localparam int unsigned NPAD   = NUNIT * GRP;
  localparam bit          USE2   = TWO_LEVEL && (NUNIT > 1) && (NUNIT <= GRP);

  logic [NPAD-1:0]  sl_g_n, sl_p_n, sl_c;
  logic [NUNIT-1:0] ubg_n, ubp_n;
  logic [NUNIT:0]   ucin;

  assign ucin[0] = cin;

  for (genvar i = 0; i < NPAD; i++) begin : g_slice
    if (i < NSLICE) begin : g_real
      add4_slice slice_i (
        .a  (a[i*GRP +: GRP]),
        .b  (b[i*GRP +: GRP]),
        .ci (sl_c[i]),
        .s  (sum[i*GRP +: GRP]),
        .g_n(sl_g_n[i]),
        .p_n(sl_p_n[i])
      );
    end else begin : g_pad
      assign sl_g_n[i] = 1'b1;
      assign sl_p_n[i] = 1'b0;
    end
  end

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    assign sl_c[u*GRP] = ucin[u];
    cla4_gen unit_i (
      .g_n (sl_g_n[u*GRP +: GRP]),
      .p_n (sl_p_n[u*GRP +: GRP]),
      .cin (ucin[u]),
      .c1  (sl_c[u*GRP+1]),
      .c2  (sl_c[u*GRP+2]),
      .c3  (sl_c[u*GRP+3]),
      .bg_n(ubg_n[u]),
      .bp_n(ubp_n[u])
    );
  end

  if (USE2) begin : g_level2
    grp_t up_g_n, up_p_n;
    logic [GRP-1:0] up_c;
    logic up_bg_n, up_bp_n;
    for (genvar j = 0; j < GRP; j++) begin : g_in
      if (j < NUNIT) begin : g_use
        assign up_g_n[j] = ubg_n[j];
        assign up_p_n[j] = ubp_n[j];
      end else begin : g_fill
        assign up_g_n[j] = 1'b1;
        assign up_p_n[j] = 1'b0;
      end
    end
    assign up_c[0] = cin;
    cla4_gen top_unit_i (
      .g_n (up_g_n),
      .p_n (up_p_n),
      .cin (cin),
      .c1  (up_c[1]),
      .c2  (up_c[2]),
      .c3  (up_c[3]),
      .bg_n(up_bg_n),
      .bp_n(up_bp_n)
    );
    for (genvar u = 1; u < NUNIT; u++) begin : g_carry
      assign ucin[u] = up_c[u];
    end
    assign ucin[NUNIT] = ~up_bg_n | (~up_bp_n & cin);
  end else begin : g_ripple
    for (genvar u = 0; u < NUNIT; u++) begin : g_carry
      assign ucin[u+1] = ~ubg_n[u] | (~ubp_n[u] & ucin[u]);
    end
  end

  assign cout = ucin[NUNIT];
endmodule

// File: rtl/lookahead_adder_chk.sv
module cla4_gen_chk
  import cla_pkg::*;
(
  input grp_t g_n,
  input grp_t p_n,
  input logic cin,
  input logic c1,
  input logic c2,
  input logic c3,
  input logic bg_n,
  input logic bp_n
);
  always_comb begin
    if (!$isunknown({g_n, p_n, cin, c1, c2, c3, bg_n, bp_n})) begin
      a_r1_gen0_sets_c1: assert (g_n[0] || c1)
        else $error("R1: group 0 generates but c1 low");
      a_r2_chain_c1_c2: assert (!(c1 && !p_n[1]) || c2)
        else $error("R2: c1 and P1 asserted but c2 low");
      a_r3_chain_c2_c3: assert (!(c2 && !p_n[2]) || c3)
        else $error("R3: c2 and P2 asserted but c3 low");
      a_r4_gen3_sets_blk: assert (g_n[3] || !bg_n)
        else $error("R4: group 3 generates but block generate idle");
      a_r5_blk_prop_all: assert (bp_n || (p_n == '0))
        else $error("R5: block propagate asserted with a group idle");
    end
  end
endmodule

module lookahead_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    if (!$isunknown({a, b, cin, sum, cout})) begin
      a_r7_sum_exact: assert ({cout, sum} == ref_sum)
        else $error("R7: sum mismatch");
    end
  end
endmodule

bind cla4_gen cla4_gen_chk cla4_chk_i (
  .g_n(g_n), .p_n(p_n), .cin(cin), .c1(c1), .c2(c2), .c3(c3),
  .bg_n(bg_n), .bp_n(bp_n)
);

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH)) add_chk_i (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/lookahead_adder_tb_top.sv
`timescale 1ns/1ps
module lookahead_adder_tb_top;
  import cla_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // unit under exhaustive sweep
  grp_t u_g_n, u_p_n;
  logic u_cin, u_c1, u_c2, u_c3, u_bg_n, u_bp_n;
  cla4_gen unit_i (.g_n(u_g_n), .p_n(u_p_n), .cin(u_cin), .c1(u_c1), .c2(u_c2),
                   .c3(u_c3), .bg_n(u_bg_n), .bp_n(u_bp_n));

  // small adder, exhaustive
  logic [7:0] a8, b8, s8;
  logic c8i, c8o;
  lookahead_adder #(.WIDTH(8)) dut_i (.a(a8), .b(b8), .cin(c8i), .sum(s8), .cout(c8o));

  // default width, ripple
  logic [15:0] a16, b16, s16;
  logic c16i, c16o;
  lookahead_adder #(.WIDTH(16)) d16_i (.a(a16), .b(b16), .cin(c16i), .sum(s16), .cout(c16o));

  // 28-bit, ripple and two-level
  logic [27:0] a28, b28, s28r, s28t;
  logic c28i, c28ro, c28to;
  lookahead_adder #(.WIDTH(28), .TWO_LEVEL(1'b0)) rip_i
    (.a(a28), .b(b28), .cin(c28i), .sum(s28r), .cout(c28ro));
  lookahead_adder #(.WIDTH(28), .TWO_LEVEL(1'b1)) two_i
    (.a(a28), .b(b28), .cin(c28i), .sum(s28t), .cout(c28to));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run28(input logic [27:0] x, input logic [27:0] y, input logic ci);
    logic [28:0] e;
    @(negedge clk);
    a28 = x; b28 = y; c28i = ci;
    #1;
    e = {1'b0, x} + {1'b0, y} + {28'd0, ci};
    check({c28ro, s28r} == e, "R8", {c28ro, s28r}, e);
    check({c28to, s28t} == e, "R9", {c28to, s28t}, e);
  endtask

  initial begin
    #(8 * 180000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    u_g_n = '1; u_p_n = '1; u_cin = 1'b0;
    a8 = '0; b8 = '0; c8i = 1'b0;
    a16 = '0; b16 = '0; c16i = 1'b0;
    a28 = '0; b28 = '0; c28i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // quiescent state: nothing generates, nothing propagates
    check({u_c1, u_c2, u_c3, u_bg_n, u_bp_n} == 5'b00011, "R6 idle",
          {u_c1, u_c2, u_c3, u_bg_n, u_bp_n}, 5'b00011);

    // R1..R6: all 512 unit input combinations, reference by carry recursion
    for (int v = 0; v < 512; v++) begin
      logic [3:0] g, p;
      logic c, e1, e2, e3, gg, pp;
      @(negedge clk);
      u_g_n = v[3:0]; u_p_n = v[7:4]; u_cin = v[8];
      #1;
      g = ~v[3:0]; p = ~v[7:4];
      c = v[8];
      c = g[0] | (p[0] & c); e1 = c;
      c = g[1] | (p[1] & c); e2 = c;
      c = g[2] | (p[2] & c); e3 = c;
      gg = 1'b0;
      for (int k = 0; k < 4; k++) gg = g[k] | (p[k] & gg);
      pp = (p == 4'hF);
      check(!$isunknown({u_c1, u_c2, u_c3, u_bg_n, u_bp_n}), "R6",
            {u_c1, u_c2, u_c3, u_bg_n, u_bp_n}, 0);
      check(u_c1 == e1, "R1", u_c1, e1);
      check(u_c2 == e2, "R2", u_c2, e2);
      check(u_c3 == e3, "R3", u_c3, e3);
      check(u_bg_n == ~gg, "R4", u_bg_n, ~gg);
      check(u_bp_n == ~pp, "R5", u_bp_n, ~pp);
    end

    // R7: exhaustive 8-bit adder
    for (int v = 0; v < 131072; v++) begin
      logic [8:0] e;
      @(negedge clk);
      a8 = v[7:0]; b8 = v[15:8]; c8i = v[16];
      #1;
      e = {1'b0, v[7:0]} + {1'b0, v[15:8]} + {8'd0, v[16]};
      check({c8o, s8} == e, "R7", {c8o, s8}, e);
    end

    // R7: default width, random plus corners
    for (int n = 0; n < 600; n++) begin
      logic [16:0] e;
      logic [15:0] x, y;
      logic ci;
      x = (n == 0) ? 16'hFFFF : 16'($urandom);
      y = (n == 0) ? 16'h0000 : 16'($urandom);
      ci = (n == 0) ? 1'b1 : 1'($urandom);
      @(negedge clk);
      a16 = x; b16 = y; c16i = ci;
      #1;
      e = {1'b0, x} + {1'b0, y} + {16'd0, ci};
      check({c16o, s16} == e, "R7 w16", {c16o, s16}, e);
    end

    // R8, R9: 28-bit with padded last unit
    run28(28'hFFFFFFF, 28'h0000000, 1'b1);
    run28(28'hFFFFFFF, 28'hFFFFFFF, 1'b1);
    run28(28'h0FFFFFF, 28'h0000001, 1'b0);
    run28(28'h0000000, 28'h0000000, 1'b0);
    for (int n = 0; n < 1500; n++)
      run28(28'($urandom), 28'($urandom), 1'($urandom));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule